// File: doc/BRIEF.md
# Programmable Offset-and-Period Event Generator Bank

This block turns timer strobes into programmable streams of single-cycle event pulses. Six reference strobes arrive from outside: a symbol strobe and a frame strobe from each of three radio timers (common, uplink and downlink). Each of the eight event channels chooses one of these strobes as its reference. When the chosen strobe arrives, the channel waits a programmed number of clocks and then fires its first pulse. After that it fires again every programmed period until the next reference strobe restarts the sequence.

Events come from per-channel counters, not from compare masks. A channel programmed with a period of half a symbol and a zero offset, referenced to the symbol strobe, produces a pulse at the start of every symbol and one more in its middle. A period of zero makes the channel fire once per reference strobe. Offset and period are captured when the reference strobe arrives, so software can reprogram a running channel without cutting its current sequence short. Each channel has a live enable.

Each channel is a small state machine with four states. `CH_IDLE` means disabled or not yet started. `CH_WAIT_OFS` counts the offset. `CH_REPEAT` counts periods. `CH_SPENT` means a single-shot channel has already fired. The transitions are named as follows:
- *start*: any state goes to `CH_WAIT_OFS`, or straight to `CH_REPEAT` or `CH_SPENT` when the offset is zero, on an enabled reference strobe.
- *offset done*: `CH_WAIT_OFS` goes to `CH_REPEAT`, or to `CH_SPENT` when the period is zero.
- *period done*: `CH_REPEAT` stays in `CH_REPEAT`.
- *disable*: any state goes to `CH_IDLE` while the enable is low.

Top module: `evtgen_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every event output is low and no channel runs until it sees a reference strobe.
- R2: The source select of a channel picks its reference strobe from the strobe input vector by bit index: 0 is common symbol, 1 is common frame, 2 is uplink symbol, 3 is uplink frame, 4 is downlink symbol and 5 is downlink frame. Select codes 6 and 7 pick no strobe, and the channel is then never restarted. Strobes not selected have no effect on the channel.
- R3: Take a reference strobe sampled in cycle T with a captured offset O greater than zero. The channel is silent in cycles T+1 to T+O, and its first pulse comes in cycle T+1+O.
- R4: With a captured period M greater than zero, further pulses follow the first one every M cycles, for example every 320 cycles when M is 320.
- R5: With a captured period of zero, the channel fires exactly once per reference strobe.
- R6: A reference strobe restarts the offset and the period count from the start, whether the channel is counting its offset, repeating, or has finished.
- R7: While a channel's enable is low, its output is low and its reference strobes are ignored. After the enable returns high, the channel stays silent until its next reference strobe.
- R8: Offset and period are captured only when a reference strobe is accepted. A change to either input afterwards does not alter the running sequence.
- R9: Channels are independent: the configuration and strobes of one channel do not affect any other channel.
- R10: With a captured offset of zero, the first pulse comes in the cycle right after the reference strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 6 | Reference strobes, using the bit order given in R2 |
| ch_en_i | input | 8 | Live enable per channel |
| ch_sel_i | input | 24 | Source select, 3 bits per channel; channel k uses bits [3k+2:3k] |
| ch_offset_i | input | 160 | Offset in clocks, 20 bits per channel |
| ch_period_i | input | 160 | Period in clocks, 20 bits per channel; 0 means single shot |
| event_o | output | 8 | One-cycle event pulse per channel |

## Verification
The assertions check several properties on every cycle:
- a disabled channel falls back to idle with no pending pulse;
- an accepted strobe always leaves the channel running;
- the offset and period counters never pass their captured limits;
- a single-shot channel that has fired stays silent;
- the captured offset and period stay unchanged between strobes;
- out-of-range select codes produce no reference.

Only the bench scenarios can show the exact pulse timing after each strobe, the restart partway through a sequence, and the independence of channels. The bench shows these by comparing every output on every cycle against a model of pulse times measured from the last accepted strobe.

// File: rtl/evtgen_pkg.sv
package evtgen_pkg;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_WAIT_OFS = 2'd1,
        CH_REPEAT   = 2'd2,
        CH_SPENT    = 2'd3
    } ch_state_e;

    localparam int unsigned REF_SOURCES = 6;

endpackage

// File: rtl/evtgen_ref_mux.sv
module evtgen_ref_mux #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] strobes_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               ref_o
);

    always_comb begin
        ref_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) begin
                ref_o = strobes_i[i];
            end
        end
    end

    // Codes past the last source never select a strobe.
    always_comb begin
        if (32'(sel_i) >= NUM_SRC) begin
            assert_sel_range_R2: assert (ref_o == 1'b0)
                else $error("out-of-range select produced a reference");
        end
    end

endmodule

// File: rtl/evtgen_channel.sv
module evtgen_channel
    import evtgen_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ref_i,
    input  logic [CNT_W-1:0] offset_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             evt_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ofs_q, ofs_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic             fire_q, fire_d;

    // Next-state and datapath logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ofs_d   = ofs_q;
        per_d   = per_q;
        fire_d  = 1'b0;
        if (!en_i) begin
            // disable
            state_d = CH_IDLE;
            cnt_d   = '0;
        end else if (ref_i) begin
            // start: capture configuration, restart counting
            ofs_d = offset_i;
            per_d = period_i;
            cnt_d = CNT_ONE;
            if (offset_i == '0) begin
                fire_d  = 1'b1;
                state_d = (period_i == '0) ? CH_SPENT : CH_REPEAT;
            end else begin
                state_d = CH_WAIT_OFS;
            end
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    state_d = CH_IDLE;
                end
                CH_SPENT: begin
                    state_d = CH_SPENT;
                end
                CH_WAIT_OFS: begin
                    if (cnt_q == ofs_q) begin
                        // offset done
                        fire_d  = 1'b1;
                        cnt_d   = CNT_ONE;
                        state_d = (per_q == '0) ? CH_SPENT : CH_REPEAT;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                CH_REPEAT: begin
                    if (cnt_q == per_q) begin
                        // period done
                        fire_d = 1'b1;
                        cnt_d  = CNT_ONE;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                default: begin
                    state_d = CH_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            ofs_q   <= '0;
            per_q   <= '0;
            fire_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ofs_q   <= ofs_d;
            per_q   <= per_d;
            fire_q  <= fire_d;
        end
    end

    // Output: registered pulse gated by the live enable.
    always_comb begin
        evt_o = fire_q & en_i;
    end

    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == CH_IDLE) && !fire_q)
        else $error("channel kept running while disabled");

    assert_strobe_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ref_i) |=> (state_q != CH_IDLE))
        else $error("accepted strobe left channel idle");

    assert_offset_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT_OFS) |-> (cnt_q <= ofs_q) && (ofs_q != '0))
        else $error("offset counter out of range");

    assert_period_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_REPEAT) |-> (cnt_q <= per_q) && (per_q != '0))
        else $error("period counter out of range");

    assert_single_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT && !(en_i && ref_i)) |=> !fire_q)
        else $error("single-shot channel fired again");

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ref_i) |=> ($stable(ofs_q) && $stable(per_q)))
        else $error("captured configuration changed without a strobe");

endmodule

// File: rtl/evtgen_bank.sv
module evtgen_bank
    import evtgen_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 20
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [REF_SOURCES-1:0]             strobe_i,
    input  logic [NUM_CH-1:0]                  ch_en_i,
    input  logic [NUM_CH*$clog2(REF_SOURCES+1)-1:0] ch_sel_i,
    input  logic [NUM_CH*CNT_W-1:0]            ch_offset_i,
    input  logic [NUM_CH*CNT_W-1:0]            ch_period_i,
    output logic [NUM_CH-1:0]                  event_o
);

    localparam int unsigned SEL_W = $clog2(REF_SOURCES + 1);

    logic [NUM_CH-1:0] ref_hit;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        evtgen_ref_mux #(
            .NUM_SRC (REF_SOURCES),
            .SEL_W   (SEL_W)
        ) u_mux (
            .strobes_i (strobe_i),
            .sel_i     (ch_sel_i[k*SEL_W +: SEL_W]),
            .ref_o     (ref_hit[k])
        );

        evtgen_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ch_en_i[k]),
            .ref_i    (ref_hit[k]),
            .offset_i (ch_offset_i[k*CNT_W +: CNT_W]),
            .period_i (ch_period_i[k*CNT_W +: CNT_W]),
            .evt_o    (event_o[k])
        );
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (event_o == '0))
        else $error("event pulse right after reset");

endmodule

// File: tb/evtgen_bank_bench.sv
module evtgen_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int CW   = 20;
    localparam int SW   = 3;
    localparam int NSRC = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSRC-1:0]      strb = '0;
    logic [NCH-1:0]       en = '0;
    logic [NCH*SW-1:0]    sel_v;
    logic [NCH*CW-1:0]    off_v, per_v;
    logic [NCH-1:0]       event_o;

    int sel_a [NCH];
    int off_a [NCH];
    int per_a [NCH];

    // model state
    bit alive [NCH];
    int ts [NCH];
    int lo [NCH];
    int lm [NCH];

    int cyc = 0;
    int total = 0;
    int bad = 0;
    string phase = "R9";
    bit timed_out = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            sel_v[k*SW +: SW] = SW'(sel_a[k]);
            off_v[k*CW +: CW] = CW'(off_a[k]);
            per_v[k*CW +: CW] = CW'(per_a[k]);
        end
    end

    evtgen_bank #(.NUM_CH(NCH), .CNT_W(CW)) u_evtgen_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strb),
        .ch_en_i     (en),
        .ch_sel_i    (sel_v),
        .ch_offset_i (off_v),
        .ch_period_i (per_v),
        .event_o     (event_o)
    );

    function automatic bit expect_evt(int k, int c);
        int d;
        if (!alive[k] || !en[k]) return 1'b0;
        d = c - ts[k] - 1;
        if (d == lo[k]) return 1'b1;
        if (lm[k] > 0 && d > lo[k] && ((d - lo[k]) % lm[k]) == 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(int k, int c);
        int d;
        if (!en[k]) return "R7";
        if (!alive[k]) return "R2";
        d = c - ts[k] - 1;
        if (lo[k] == 0 && d == 0) return "R10";
        if (d <= lo[k]) return "R3";
        if (lm[k] == 0) return "R5";
        return "R4";
    endfunction

    task automatic check_bit(string tag, int k, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s/%s ch%0d cycle %0d: got %0b expected %0b",
                     tag, phase, k, cyc, act, exp);
        end
    endtask

    // Inputs for the current cycle are already driven (at a negedge).
    task automatic run_cycle();
        #1;
        for (int k = 0; k < NCH; k++) begin
            check_bit(tag_of(k, cyc), k, event_o[k], expect_evt(k, cyc));
        end
        for (int k = 0; k < NCH; k++) begin
            if (!en[k]) begin
                alive[k] = 1'b0;
            end else if (sel_a[k] < NSRC && strb[sel_a[k]]) begin
                alive[k] = 1'b1;
                ts[k] = cyc;
                lo[k] = off_a[k];
                lm[k] = per_a[k];
            end
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) begin
            strb = '0;
            run_cycle();
        end
    endtask

    task automatic pulse_src(int s);
        strb = '0;
        strb[s] = 1'b1;
        run_cycle();
        strb = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        timed_out = 1;
        total++;
        bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5077));
        for (int k = 0; k < NCH; k++) begin
            sel_a[k] = k % NSRC; off_a[k] = 0; per_a[k] = 0;
            alive[k] = 0; ts[k] = 0; lo[k] = 0; lm[k] = 0;
        end

        // R1: reset holds outputs low even with strobes and enables active
        en = '1;
        strb = '1;
        repeat (3) begin
            @(negedge clk);
            #1;
            for (int k = 0; k < NCH; k++) check_bit("R1", k, event_o[k], 1'b0);
        end
        strb = '0;
        @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        idle_cycles(4);

        // R10 / R4: zero offset, period 320 on common symbol
        phase = "R4";
        en = 8'h01; sel_a[0] = 0; off_a[0] = 0; per_a[0] = 320;
        pulse_src(0);
        idle_cycles(1000);

        // R3 / R5: offset with single shot
        phase = "R5";
        en = 8'h02; sel_a[1] = 3; off_a[1] = 17; per_a[1] = 0;
        pulse_src(3);
        idle_cycles(60);

        // R6: restart in the middle of the offset and in the middle of repeat
        phase = "R6";
        en = 8'h04; sel_a[2] = 4; off_a[2] = 12; per_a[2] = 5;
        pulse_src(4);
        idle_cycles(6);
        pulse_src(4);
        idle_cycles(20);
        pulse_src(4);
        idle_cycles(30);

        // R8: change config while running
        phase = "R8";
        en = 8'h08; sel_a[3] = 5; off_a[3] = 3; per_a[3] = 7;
        pulse_src(5);
        idle_cycles(5);
        off_a[3] = 1; per_a[3] = 2;
        idle_cycles(40);

        // R2: out-of-range select and unselected strobes
        phase = "R2";
        en = 8'h30; sel_a[4] = 6; sel_a[5] = 1; off_a[4] = 0; off_a[5] = 0;
        per_a[4] = 2; per_a[5] = 3;
        strb = 6'b111101;
        run_cycle();
        idle_cycles(20);

        // R7: disable, strobe while disabled, re-enable without strobe
        phase = "R7";
        en = 8'h40; sel_a[6] = 2; off_a[6] = 2; per_a[6] = 4;
        pulse_src(2);
        idle_cycles(10);
        en = 8'h00;
        pulse_src(2);
        idle_cycles(3);
        en = 8'h40;
        idle_cycles(30);

        // R9: random mix across all channels
        phase = "R9";
        for (int it = 0; it < 20000; it++) begin
            for (int s = 0; s < NSRC; s++) strb[s] = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 199) == 0) en[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 29) == 0) begin
                int k = $urandom_range(0, NCH-1);
                sel_a[k] = $urandom_range(0, 7);
                off_a[k] = $urandom_range(0, 30);
                per_a[k] = $urandom_range(0, 20);
            end
            if (it == 0) en = 8'hFF;
            run_cycle();
        end

        if (!timed_out) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule